// File: doc/BRIEF.md
# Status Register Write Gating

This block sits behind a serial peripheral interface and decides whether a write to an 8-bit status register is allowed to land. It follows the stream of instructions, each one bracketed by a low period of the active-low chip select. It keeps two pieces of state. The first is a write-enable latch, which is also visible as one bit of the status register. The second is a one-shot permission flag, which records that the instruction just finished was an enabling one. A status write is committed only if that flag is set. Every completed instruction, whatever it is, consumes the flag.

The block also answers a status-read instruction. It shifts the current status byte out, most significant bit first, and repeats it for as long as the host keeps clocking and chip select stays low. The serial inputs are assumed to be already synchronous to the system clock and slower than it by a factor of at least four. Edges of the serial clock are detected by oversampling.

Top module: `sr_write_gate`

## Requirements
- R1: After reset the status register reads 00h, the write-enable latch is clear, no write permission is held, and `spi_miso` is low.
- R2: A complete one-byte frame of opcode 06h sets the write-enable latch, which is bit 1 of `sr_value`, and grants write permission to the next instruction.
- R3: A frame of opcode 01h followed by exactly one data byte, with permission held, loads that data byte into every status bit other than bit 1. Status bits change only when a frame ends.
- R4: A complete frame of opcode 50h grants permission to the next instruction on its own, without touching the write-enable latch.
- R5: If any other complete frame comes between the enabling frame and the 01h frame, the status write is ignored and `sr_value` is left unchanged.
- R6: A status write that is accepted clears bit 1 of `sr_value`, whatever value the data byte carries in that bit.
- R7: A frame in which chip select rises with a byte half-shifted, or with no bits shifted at all, changes no status bit and withdraws any permission held.
- R8: A 01h frame with no data byte or with more than one data byte is rejected, and it still consumes the permission.
- R9: After opcode 05h, `spi_miso` presents the status byte MSB first, one bit per serial clock. The value is sampled by the host on the rising edge. The byte repeats until chip select rises.
- R10: One enabling frame permits at most one status write. A second 01h frame that is not preceded by a new enabling frame is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select framing each instruction |
| spi_sck | input | 1 | Serial clock, idle low, data captured on its rising edge |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| spi_miso | output | 1 | Serial data to the host, driven low when no read is active |
| sr_value | output | BYTE_W | Current status register contents, write-enable latch at bit WEL_POS |

## Verification
The assertions are checked on every cycle. They cover these properties:
- Permission can appear only right after a whole enabling frame ends.
- Any partial frame or status-write frame leaves permission cleared.
- Status bits outside the latch move only at a frame end.
- An accepted write leaves the latch clear.
- The read output holds still between serial clock edges.

Some behaviour can be shown only by the bench's frame sequences. This covers the order dependence itself: enable, then an intervening instruction, then a write. It also covers rejected write lengths, the repeated read-out of the status byte, and agreement of the whole register with a reference model across long random instruction streams.

// File: rtl/swg_pkg.sv
package swg_pkg;

    localparam logic [7:0] CMD_WR_EN    = 8'h06;
    localparam logic [7:0] CMD_SR_EN    = 8'h50;
    localparam logic [7:0] CMD_SR_WRITE = 8'h01;
    localparam logic [7:0] CMD_SR_READ  = 8'h05;

    // summary of a frame, produced when chip select rises
    typedef struct packed {
        logic       whole;   // ended on a byte boundary with at least one byte
        logic [1:0] nbytes;  // completed bytes, saturating at 3
    } frame_info_t;

endpackage

// File: rtl/swg_rx.sv
module swg_rx
    import swg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              sck_rise,
    output logic              byte_done,
    output logic [1:0]        byte_idx,
    output logic [BYTE_W-1:0] byte_val,
    output logic              frame_end,
    output frame_info_t       frame_info
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sck_prev;
        logic              cs_prev;
        logic [CNT_W-1:0]  bit_cnt;
        logic [1:0]        byte_cnt;
        logic [BYTE_W-1:0] shift;
        logic              done;
        logic [1:0]        idx;
        logic [BYTE_W-1:0] data;
        logic              fend;
        frame_info_t       info;
    } rx_state_t;

    rx_state_t s_d, s_q;

    assign sck_rise = sck & ~s_q.sck_prev & ~cs_n;

    always_comb begin
        s_d          = s_q;
        s_d.sck_prev = sck;
        s_d.cs_prev  = cs_n;
        s_d.done     = 1'b0;
        s_d.fend     = 1'b0;
        if (cs_n) begin
            s_d.bit_cnt  = '0;
            s_d.byte_cnt = '0;
            if (!s_q.cs_prev) begin
                s_d.fend        = 1'b1;
                s_d.info.whole  = (s_q.bit_cnt == '0) && (s_q.byte_cnt != 2'd0);
                s_d.info.nbytes = s_q.byte_cnt;
            end
        end else if (sck_rise) begin
            s_d.shift = {s_q.shift[BYTE_W-2:0], mosi};
            if (s_q.bit_cnt == LAST_BIT) begin
                s_d.bit_cnt = '0;
                s_d.done    = 1'b1;
                s_d.idx     = s_q.byte_cnt;
                s_d.data    = {s_q.shift[BYTE_W-2:0], mosi};
                if (s_q.byte_cnt != 2'd3) begin
                    s_d.byte_cnt = s_q.byte_cnt + 2'd1;
                end
            end else begin
                s_d.bit_cnt = s_q.bit_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.cs_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_done  = s_q.done;
    assign byte_idx   = s_q.idx;
    assign byte_val   = s_q.data;
    assign frame_end  = s_q.fend;
    assign frame_info = s_q.info;

    // R7
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(!cs_n));

endmodule

// File: rtl/swg_ctrl.sv
module swg_ctrl
    import swg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int WEL_POS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [1:0]        byte_idx,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              frame_end,
    input  frame_info_t       frame_info,
    output logic [BYTE_W-1:0] status,
    output logic              rd_load
);
    localparam logic [BYTE_W-1:0] KEEP_MASK = ~(BYTE_W'(1) << WEL_POS);

    typedef struct packed {
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] data;
        logic              arm;
        logic [BYTE_W-1:0] sr;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    assign rd_load = byte_done && (byte_idx == 2'd0) && (byte_val == BYTE_W'(CMD_SR_READ));

    always_comb begin
        s_d = s_q;
        if (byte_done) begin
            if (byte_idx == 2'd0) s_d.op   = byte_val;
            if (byte_idx == 2'd1) s_d.data = byte_val;
        end
        if (frame_end) begin
            s_d.arm = 1'b0;
            if (frame_info.whole) begin
                case (s_q.op)
                    BYTE_W'(CMD_WR_EN): begin
                        s_d.sr[WEL_POS] = 1'b1;
                        s_d.arm         = 1'b1;
                    end
                    BYTE_W'(CMD_SR_EN): begin
                        s_d.arm = 1'b1;
                    end
                    BYTE_W'(CMD_SR_WRITE): begin
                        if (s_q.arm && (frame_info.nbytes == 2'd2)) begin
                            s_d.sr          = s_q.data & KEEP_MASK;
                            s_d.sr[WEL_POS] = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status = s_q.sr;

    // R2
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.arm) |-> $past(frame_end && frame_info.whole &&
            (s_q.op == BYTE_W'(CMD_WR_EN) || s_q.op == BYTE_W'(CMD_SR_EN))));

    // R6
    wel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_info.whole && s_q.arm && frame_info.nbytes == 2'd2 &&
         s_q.op == BYTE_W'(CMD_SR_WRITE)) |=> !s_q.sr[WEL_POS]);

    // R7
    partial_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_info.whole) |=> !s_q.arm);

    // R3
    sr_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(s_q.sr & KEEP_MASK));

    // R10
    write_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && s_q.op == BYTE_W'(CMD_SR_WRITE)) |=> !s_q.arm);

endmodule

// File: rtl/swg_tx.sv
module swg_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              rd_load,
    input  logic [BYTE_W-1:0] status,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cs_n) begin
            s_d = '0;
        end else if (rd_load) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.sh     = status;
        end else if (s_q.active && sck_rise) begin
            if (s_q.cnt == LAST_BIT) begin
                s_d.cnt = '0;
                s_d.sh  = status;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
                s_d.sh  = {s_q.sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign miso = s_q.active & s_q.sh[BYTE_W-1];

    // R9
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !cs_n && !sck_rise && !rd_load) |=> $stable(miso));

endmodule

// File: rtl/sr_write_gate.sv
module sr_write_gate
    import swg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int WEL_POS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [BYTE_W-1:0] sr_value
);
    logic              sck_rise;
    logic              byte_done;
    logic [1:0]        byte_idx;
    logic [BYTE_W-1:0] byte_val;
    logic              frame_end;
    frame_info_t       frame_info;
    logic              rd_load;

    swg_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .sck_rise   (sck_rise),
        .byte_done  (byte_done),
        .byte_idx   (byte_idx),
        .byte_val   (byte_val),
        .frame_end  (frame_end),
        .frame_info (frame_info)
    );

    swg_ctrl #(.BYTE_W(BYTE_W), .WEL_POS(WEL_POS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_done  (byte_done),
        .byte_idx   (byte_idx),
        .byte_val   (byte_val),
        .frame_end  (frame_end),
        .frame_info (frame_info),
        .status     (sr_value),
        .rd_load    (rd_load)
    );

    swg_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .rd_load  (rd_load),
        .status   (sr_value),
        .miso     (spi_miso)
    );

    // R1
    idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n) |-> !spi_miso);

endmodule

// File: tb/sim_sr_write_gate.sv
`timescale 1ns/1ps
module sim_sr_write_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [7:0] sr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_sr  = 8'h00;
    logic       m_arm = 1'b0;

    always #2.5 clk = ~clk;

    sr_write_gate u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (cs_n),
        .spi_sck  (sck),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .sr_value (sr)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // reference model applied at the end of each frame
    task automatic model(input logic [7:0] op, input logic [7:0] d, input int nb, input int xb);
        if (nb == 0 || xb != 0) begin
            m_arm = 1'b0;
        end else begin
            case (op)
                8'h06: begin m_sr[1] = 1'b1; m_arm = 1'b1; end
                8'h50: m_arm = 1'b1;
                8'h01: begin
                    if (m_arm && nb == 2) m_sr = d & 8'hFD;
                    m_arm = 1'b0;
                end
                default: m_arm = 1'b0;
            endcase
        end
    endtask

    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input int nb, input int xb,
                         output logic [7:0] r1, output logic [7:0] r2);
        logic [7:0] bt [3];
        bt[0] = b0; bt[1] = b1; bt[2] = b2;
        r1 = 8'h00; r2 = 8'h00;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            for (int k = 7; k >= 0; k--) begin
                mosi = bt[i][k];
                repeat (4) @(negedge clk);
                if (i == 1) r1[k] = miso;
                if (i == 2) r2[k] = miso;
                sck = 1'b1;
                repeat (4) @(negedge clk);
                sck = 1'b0;
            end
        end
        for (int k = 0; k < xb; k++) begin
            mosi = (nb < 3) ? bt[nb][7-k] : 1'b0;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        model(b0, b1, nb, xb);
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] d, input int nb);
        logic [7:0] a, b;
        frame(op, d, 8'h00, nb, 0, a, b);
    endtask

    initial begin
        logic [7:0] r1, r2, pre, op;
        int nb, xb, sel;
        sel = int'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 reset status", sr, 8'h00);
        check8("R1 reset miso", {7'd0, miso}, 8'h00);

        cmd(8'h06, 8'h00, 1);
        check8("R2 write enable sets latch", sr, 8'h02);
        cmd(8'h01, 8'hA5, 2);
        check8("R3 enabled write lands", sr, 8'hA5);
        cmd(8'h01, 8'h3C, 2);
        check8("R10 second write ignored", sr, 8'hA5);
        cmd(8'h50, 8'h00, 1);
        check8("R4 status enable leaves latch", sr, 8'hA5);
        cmd(8'h01, 8'hFF, 2);
        check8("R6 accepted write clears latch", sr, 8'hFD);
        cmd(8'h06, 8'h00, 1);
        frame(8'h05, 8'h00, 8'h00, 3, 0, r1, r2);
        check8("R9 read byte 1", r1, 8'hFF);
        check8("R9 read byte 2 repeat", r2, 8'hFF);
        cmd(8'h01, 8'h00, 2);
        check8("R5 intervening read cancels", sr, 8'hFF);
        cmd(8'h50, 8'h00, 1);
        cmd(8'h01, 8'h00, 2);
        check8("R3 clear via status enable", sr, 8'h00);
        frame(8'h06, 8'h00, 8'h00, 0, 5, r1, r2);
        check8("R7 partial write enable ignored", sr, 8'h00);
        cmd(8'h50, 8'h00, 1);
        frame(8'h9F, 8'h00, 8'h00, 1, 4, r1, r2);
        cmd(8'h01, 8'h11, 2);
        check8("R7 partial frame drops permission", sr, 8'h00);
        cmd(8'h06, 8'h00, 1);
        frame(8'h01, 8'h55, 8'h66, 3, 0, r1, r2);
        check8("R8 long write rejected", sr, 8'h02);
        cmd(8'h01, 8'h55, 2);
        check8("R8 long write consumed permission", sr, 8'h02);
        cmd(8'h50, 8'h00, 1);
        cmd(8'h01, 8'h00, 1);
        cmd(8'h01, 8'h80, 2);
        check8("R8 short write consumed permission", sr, 8'h02);

        for (int n = 0; n < 220; n++) begin
            sel = int'($urandom_range(0, 5));
            case (sel)
                0: op = 8'h06;
                1: op = 8'h50;
                2, 3: op = 8'h01;
                4: op = 8'h05;
                default: op = 8'($urandom());
            endcase
            nb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 2;
            xb = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 7)) : 0;
            pre = m_sr;
            frame(op, 8'($urandom()), 8'($urandom()), nb, xb, r1, r2);
            check8("R3 R5 R10 random status", sr, m_sr);
            if (op == 8'h05 && nb >= 2) check8("R9 random read", r1, pre);
            if (op == 8'h05 && nb == 3) check8("R9 random repeat", r2, pre);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule